// File: doc/BRIEF.md
# Byte-Wide Memory Burst Write and Completion Poll Controller

This block sits on the host side of a byte-wide nonvolatile memory that accepts a short burst of byte loads into one page and then programs them internally. A command names a start address, the number of bytes less one and a completion mode. The bytes then arrive one at a time on a separate valid/ready stream. For each byte the controller generates a write strobe with its own setup, low time and hold. Every load after the first must begin soon enough after the previous one that the memory does not close the burst on its own.

Once the last byte is loaded, the controller does not wait a fixed worst-case delay. It reads the memory in a loop until the memory reports that programming is complete. In data-check mode it reads the last loaded address and compares the top data bit with the top bit of the byte it saved. In alternating-bit mode it compares bit 6 of each read with bit 6 of the previous read. A completion pulse ends the operation. If completion is not seen within a bounded number of poll cycles, an error pulse ends it instead. If the byte stream stalls past the spacing window, the burst is closed early, a flag records this, and polling continues for the last byte actually loaded.

Top module: `eeprom_wpoll_ctrl`

## Requirements
- R1: `cmd_ready` is high only while the controller is idle. After reset and in idle, the chip-enable, output-enable and write-enable strobes are all high (inactive) and `mem_doe` is low. A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high, and `cmd_ready` stays low from then until the operation ends.
- R2: Each byte load holds `mem_we_n` and `mem_ce_n` low, with `mem_oe_n` high, for exactly T_PULSE cycles. `mem_doe` is high, with address and data stable, for at least T_SETUP cycles before the strobe falls and while it is low. The rising edge of the strobe occurs while the data is still driven.
- R3: A command with length field L (6 bits) loads exactly L+1 bytes. The first byte goes to the command address, and each later byte goes to the next column, where the column is address bits 5..0 and wraps from 63 to 0. Address bits 12..6 never change during the operation.
- R4: The number of cycles between consecutive falling edges of `mem_we_n` in one burst is always below T_GAP_MAX. `dat_ready` is high for a byte after the first only while that byte can still meet this limit.
- R5: If the next byte is not offered within the spacing window, the remaining bytes are dropped and `cut` goes high for the rest of the operation. The controller then polls for the last loaded byte. `cut` is low for a burst in which every byte is loaded.
- R6: Each poll read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for exactly T_RD cycles, with `mem_doe` low. Both strobes stay high for at least T_REC cycles between reads. The read address is the last loaded address.
- R7: When `cmd_mode` is 0 (data check), `done` is raised only after a read whose bit 7 equals bit 7 of the last loaded byte. It is never raised while the memory still returns the inverted bit.
- R8: When `cmd_mode` is 1 (alternating bit), `done` is raised only after two consecutive reads return the same bit 6. While bit 6 changes from read to read, polling continues.
- R9: If completion is not seen within T_TIMEOUT cycles of polling, `err` pulses, `done` does not, and the controller returns to idle.
- R10: `done` and `err` are single-cycle pulses and are never high together. `cmd_ready` is high in the cycle after either pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_addr | input | ADDR_W | Address of the first byte |
| cmd_len | input | COL_W | Number of bytes less one |
| cmd_mode | input | 1 | 0 = data-check polling, 1 = alternating-bit polling |
| dat_valid | input | 1 | Next burst byte offered |
| dat_ready | output | 1 | Next byte can be taken now |
| dat_byte | input | DATA_W | Burst byte |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dout | output | DATA_W | Data driven toward the memory |
| mem_doe | output | 1 | Data bus drive enable |
| mem_din | input | DATA_W | Data returned by the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| done | output | 1 | Operation complete pulse |
| err | output | 1 | Completion timeout pulse |
| cut | output | 1 | Burst was closed early by the spacing window |

## Verification
A wrong column or page register shows up as soon as the strobe of the affected byte rises: the byte lands at the wrong location, or a load or read appears outside the commanded page. A slip in the cycle counter changes a strobe width or a load spacing during the same burst. Because the bench measures every strobe run length, such a slip is caught on the first affected strobe. A wrong saved bit or a stale previous sample changes whether `done` appears while the memory model still reports busy, which shows as an early completion or as an `err` pulse once the poll timeout has run out.

// File: rtl/eeprom_wpoll_pkg.sv
// Shared types for the burst write and completion poll controller.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package eeprom_wpoll_pkg;

    // Controller phases: byte wait, load strobe (setup/low/hold), poll read (recovery/access), result
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT,
        ST_WSET,
        ST_WPUL,
        ST_WHLD,
        ST_RSET,
        ST_RACC,
        ST_DONE,
        ST_FAIL
    } wp_state_e;

    // Completion detection method
    typedef enum logic {
        POLL_DATA   = 1'b0,
        POLL_TOGGLE = 1'b1
    } poll_mode_e;

endpackage

// File: rtl/eeprom_wpoll_judge.sv
// Completion judge: keeps the top bit of the last loaded byte and the
// previous alternating-bit sample, and says whether the current poll
// sample means the memory is ready.
// Assumes: smp_en is high for exactly one cycle per poll read; arm is
// high whenever polling is not in progress.
module eeprom_wpoll_judge
    import eeprom_wpoll_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_en,
    input  logic       ld_msb,
    input  logic       arm,
    input  logic       smp_en,
    input  logic       smp_msb,
    input  logic       smp_tog,
    input  poll_mode_e mode,
    output logic       hit
);

    logic saved_msb;
    logic have_prev;
    logic prev_tog;

    // Hold the reference bit and the alternating-bit history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_msb <= 1'b0;
            have_prev <= 1'b0;
            prev_tog  <= 1'b0;
        end else begin
            if (ld_en)
                saved_msb <= ld_msb;
            if (arm)
                have_prev <= 1'b0;
            else if (smp_en) begin
                have_prev <= 1'b1;
                prev_tog  <= smp_tog;
            end
        end
    end

    // Ready decision for the sample on the bus this cycle
    always_comb begin
        if (mode == POLL_DATA)
            hit = (smp_msb == saved_msb);
        else
            hit = have_prev && (smp_tog == prev_tog);
    end

endmodule

// File: rtl/eeprom_wpoll_tmo.sv
// Poll timeout counter: counts cycles while run is high and saturates
// at LIMIT; expired is high once LIMIT cycles have been counted.
// Assumes: clr and run are never high together.
module eeprom_wpoll_tmo #(
    parameter int LIMIT = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Count poll cycles up to the limit
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (run && cnt != CW'(LIMIT))
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == CW'(LIMIT));

endmodule

// File: rtl/eeprom_wpoll_seq.sv
// Sequencer: takes a command, loads each byte with setup/low/hold
// phases, enforces the load spacing window, then runs poll reads until
// the judge reports ready or the timeout expires.
// Assumes: all timing parameters are at least 1 and
// T_GAP_MAX > T_SETUP + T_PULSE + T_HOLD + 1.
module eeprom_wpoll_seq
    import eeprom_wpoll_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int COL_W     = 6,
    parameter int T_SETUP   = 2,
    parameter int T_PULSE   = 4,
    parameter int T_HOLD    = 2,
    parameter int T_GAP_MAX = 20,
    parameter int T_REC     = 2,
    parameter int T_RD      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [COL_W-1:0]  cmd_len,
    input  logic              cmd_mode,
    input  logic              dat_valid,
    output logic              dat_ready,
    input  logic [DATA_W-1:0] dat_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_doe,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    input  logic              hit,
    input  logic              tmo_exp,
    output logic              ld_en,
    output logic              smp_en,
    output logic              poll_run,
    output poll_mode_e        mode,
    output logic              done,
    output logic              err,
    output logic              cut
);

    localparam int PAGE_W = ADDR_W - COL_W;
    localparam int W_MAX  = T_GAP_MAX - T_PULSE - T_HOLD - T_SETUP - 1;
    localparam int TSPAN  = T_SETUP + T_PULSE + T_HOLD + T_GAP_MAX + T_REC + T_RD;
    localparam int TW     = $clog2(TSPAN + 1);

    wp_state_e          state;
    logic [TW-1:0]      tcnt;
    logic [PAGE_W-1:0]  page;
    logic [COL_W-1:0]   col;
    logic [COL_W-1:0]   left;
    logic [DATA_W-1:0]  data_q;
    logic               first_q;
    logic               cut_q;
    logic               wait_expire;

    // Handshake and strobe decode from the current phase
    always_comb begin
        cmd_ready   = (state == ST_IDLE);
        dat_ready   = (state == ST_WAIT) && (first_q || tcnt < TW'(W_MAX));
        wait_expire = (state == ST_WAIT) && !first_q && tcnt >= TW'(W_MAX);
        ld_en       = dat_valid && dat_ready;
        smp_en      = (state == ST_RACC) && (tcnt == TW'(T_RD - 1));
        poll_run    = (state == ST_RSET) || (state == ST_RACC);
        mem_addr    = {page, col};
        mem_dout    = data_q;
        mem_doe     = (state == ST_WSET) || (state == ST_WPUL) || (state == ST_WHLD);
        mem_we_n    = (state != ST_WPUL);
        mem_oe_n    = (state != ST_RACC);
        mem_ce_n    = !((state == ST_WPUL) || (state == ST_RACC));
        done        = (state == ST_DONE);
        err         = (state == ST_FAIL);
        cut         = cut_q;
    end

    // Phase sequencing, byte bookkeeping and phase timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tcnt    <= '0;
            page    <= '0;
            col     <= '0;
            left    <= '0;
            data_q  <= '0;
            first_q <= 1'b0;
            cut_q   <= 1'b0;
            mode    <= POLL_DATA;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        page    <= cmd_addr[ADDR_W-1:COL_W];
                        col     <= cmd_addr[COL_W-1:0];
                        left    <= cmd_len;
                        mode    <= poll_mode_e'(cmd_mode);
                        first_q <= 1'b1;
                        cut_q   <= 1'b0;
                        tcnt    <= '0;
                        state   <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (ld_en) begin
                        data_q  <= dat_byte;
                        if (!first_q)
                            col <= col + 1'b1;
                        first_q <= 1'b0;
                        tcnt    <= '0;
                        state   <= ST_WSET;
                    end else if (wait_expire) begin
                        cut_q <= 1'b1;
                        tcnt  <= '0;
                        state <= ST_RSET;
                    end else
                        tcnt <= tcnt + 1'b1;
                end
                ST_WSET: begin
                    tcnt <= tcnt + 1'b1;
                    if (tcnt == TW'(T_SETUP - 1)) begin
                        tcnt  <= '0;
                        state <= ST_WPUL;
                    end
                end
                ST_WPUL: begin
                    tcnt <= tcnt + 1'b1;
                    if (tcnt == TW'(T_PULSE - 1)) begin
                        tcnt  <= '0;
                        state <= ST_WHLD;
                    end
                end
                ST_WHLD: begin
                    tcnt <= tcnt + 1'b1;
                    if (tcnt == TW'(T_HOLD - 1)) begin
                        tcnt <= '0;
                        if (left == '0)
                            state <= ST_RSET;
                        else begin
                            left  <= left - 1'b1;
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_RSET: begin
                    tcnt <= tcnt + 1'b1;
                    if (tcnt == TW'(T_REC - 1)) begin
                        tcnt  <= '0;
                        state <= ST_RACC;
                    end
                end
                ST_RACC: begin
                    tcnt <= tcnt + 1'b1;
                    if (smp_en) begin
                        tcnt <= '0;
                        if (hit)
                            state <= ST_DONE;
                        else if (tmo_exp)
                            state <= ST_FAIL;
                        else
                            state <= ST_RSET;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eeprom_wpoll_ctrl.sv
// Top level: ties the sequencer to the completion judge and the poll
// timeout counter, and exposes the command, byte and memory buses.
// Assumes: the memory returns read data within T_RD cycles of both
// chip enable and output enable going low.
module eeprom_wpoll_ctrl
    import eeprom_wpoll_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int COL_W     = 6,
    parameter int T_SETUP   = 2,
    parameter int T_PULSE   = 4,
    parameter int T_HOLD    = 2,
    parameter int T_GAP_MAX = 20,
    parameter int T_REC     = 2,
    parameter int T_RD      = 3,
    parameter int T_TIMEOUT = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [COL_W-1:0]  cmd_len,
    input  logic              cmd_mode,
    input  logic              dat_valid,
    output logic              dat_ready,
    input  logic [DATA_W-1:0] dat_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_doe,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              done,
    output logic              err,
    output logic              cut
);

    localparam int DP_BIT = DATA_W - 1;
    localparam int TG_BIT = DATA_W - 2;

    logic       hit;
    logic       tmo_exp;
    logic       ld_en;
    logic       smp_en;
    logic       poll_run;
    poll_mode_e mode;

    eeprom_wpoll_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W),
        .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD),
        .T_GAP_MAX(T_GAP_MAX), .T_REC(T_REC), .T_RD(T_RD)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_mode(cmd_mode),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .hit(hit), .tmo_exp(tmo_exp), .ld_en(ld_en), .smp_en(smp_en),
        .poll_run(poll_run), .mode(mode),
        .done(done), .err(err), .cut(cut)
    );

    eeprom_wpoll_judge u_judge (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_msb(dat_byte[DP_BIT]),
        .arm(!poll_run), .smp_en(smp_en),
        .smp_msb(mem_din[DP_BIT]), .smp_tog(mem_din[TG_BIT]),
        .mode(mode), .hit(hit)
    );

    eeprom_wpoll_tmo #(.LIMIT(T_TIMEOUT)) u_tmo (
        .clk(clk), .rst_n(rst_n),
        .clr(!poll_run), .run(poll_run), .expired(tmo_exp)
    );

endmodule

// File: rtl/eeprom_wpoll_chk.sv
// Protocol checker for the controller's memory and command buses.
// Assumes: bound to eeprom_wpoll_ctrl; observes ports only.
module eeprom_wpoll_chk #(
    parameter int PAGE_W    = 7,
    parameter int T_GAP_MAX = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [PAGE_W-1:0] cmd_page,
    input logic [PAGE_W-1:0] mem_page,
    input logic              mem_doe,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              done,
    input logic              err
);

    localparam int GW = $clog2(T_GAP_MAX + 1);

    logic [PAGE_W-1:0] pg_q;
    logic [GW-1:0]     gcnt;
    logic              we_q;

    // Track the commanded page and the cycles since the last load strobe fell
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_q <= '0;
            gcnt <= '0;
            we_q <= 1'b1;
        end else begin
            we_q <= mem_we_n;
            if (cmd_valid && cmd_ready) begin
                pg_q <= cmd_page;
                gcnt <= '0;
            end else if (we_q && !mem_we_n)
                gcnt <= GW'(1);
            else if (gcnt != '0 && gcnt != GW'(T_GAP_MAX))
                gcnt <= gcnt + 1'b1;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_doe));

    // R2
    load_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_doe));

    // R3
    page_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> (mem_page == pg_q));

    // R4
    load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_we_n) && gcnt != '0) |-> (gcnt < GW'(T_GAP_MAX)));

    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_doe && mem_we_n && !mem_ce_n));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !err && cmd_ready));

    // R10
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!err && !done && cmd_ready));

endmodule

bind eeprom_wpoll_ctrl eeprom_wpoll_chk #(
    .PAGE_W(ADDR_W - COL_W),
    .T_GAP_MAX(T_GAP_MAX)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_page(cmd_addr[ADDR_W-1:COL_W]),
    .mem_page(mem_addr[ADDR_W-1:COL_W]),
    .mem_doe(mem_doe),
    .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n),
    .done(done),
    .err(err)
);

// File: tb/eeprom_wpoll_ctrl_tb.sv
// Directed bench with a behavioural page-write memory model.
module eeprom_wpoll_ctrl_tb;

    localparam int T_SETUP   = 2;
    localparam int T_PULSE   = 4;
    localparam int T_HOLD    = 2;
    localparam int T_GAP_MAX = 20;
    localparam int T_REC     = 2;
    localparam int T_RD      = 3;
    localparam int T_TIMEOUT = 400;
    localparam int PROG_DEF  = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [12:0] cmd_addr = '0;
    logic [5:0]  cmd_len = '0;
    logic        cmd_mode = 1'b0;
    logic        dat_valid = 1'b0;
    logic        dat_ready;
    logic [7:0]  dat_byte = '0;
    logic [12:0] mem_addr;
    logic [7:0]  mem_dout;
    logic        mem_doe;
    logic [7:0]  mem_din;
    logic        mem_ce_n, mem_oe_n, mem_we_n;
    logic        done, err, cut;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // memory model state
    logic [7:0]  mem_pg [64];
    logic [12:0] m_last_addr = '0;
    logic [7:0]  m_last_data = '0;
    logic        tog = 1'b0;
    int          busy_cnt = 0;
    int          prog_len = PROG_DEF;

    // monitor state
    logic        prev_we = 1'b1, prev_rd = 1'b0;
    int we_run = 0, rd_run = 0, hi_run = 0, doe_run = 0;
    int loads = 0, reads = 0, last_fall = 0, gap_max = 0;
    int pulse_bad = 0, setup_bad = 0, read_bad = 0, page_bad = 0;
    int first_rd_cyc = 0;
    logic [6:0] exp_page = '0;

    // per-burst results
    logic got_done, got_err, cut_at_end, post_ok, burst_over;
    int   busy_at_done, end_cyc;

    eeprom_wpoll_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_mode(cmd_mode),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
        .mem_din(mem_din), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .done(done), .err(err), .cut(cut)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run is a failure that still reaches the summary
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d exp<=150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Memory read data: inverted top bit / toggling bit 6 while busy
    always_comb begin
        if (!mem_ce_n && !mem_oe_n) begin
            if (busy_cnt > 0)
                mem_din = (mem_addr == m_last_addr) ?
                          {~m_last_data[7], tog, m_last_data[5:0]} : {1'b0, tog, 6'b0};
            else
                mem_din = mem_pg[mem_addr[5:0]];
        end else
            mem_din = 8'h00;
    end

    // Memory model and strobe monitor, sampled mid-cycle
    always @(negedge clk) begin
        logic rd;
        rd = !mem_ce_n && !mem_oe_n;
        if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
        // load strobe
        if (!mem_we_n) begin
            if (prev_we) begin
                loads = loads + 1;
                if (loads > 1 && (cyc - last_fall) > gap_max) gap_max = cyc - last_fall;
                last_fall = cyc;
                if (doe_run < T_SETUP) setup_bad = setup_bad + 1;
                if (mem_addr[12:6] != exp_page) page_bad = page_bad + 1;
                busy_cnt = prog_len;
            end
            we_run = we_run + 1;
        end else if (!prev_we) begin
            if (we_run != T_PULSE || !mem_doe) pulse_bad = pulse_bad + 1;
            mem_pg[mem_addr[5:0]] = mem_dout;
            m_last_addr = mem_addr;
            m_last_data = mem_dout;
            we_run = 0;
        end
        if (mem_doe && mem_we_n) doe_run = doe_run + 1;
        else if (!mem_doe) doe_run = 0;
        // poll reads
        if (rd) begin
            if (!prev_rd) begin
                if (reads == 0) first_rd_cyc = cyc;
                else if (hi_run < T_REC) read_bad = read_bad + 1;
                if (mem_addr != m_last_addr || mem_doe || !mem_we_n) read_bad = read_bad + 1;
                reads = reads + 1;
                if (busy_cnt > 0) tog = ~tog;
            end
            rd_run = rd_run + 1;
            hi_run = 0;
        end else begin
            if (prev_rd && rd_run != T_RD) read_bad = read_bad + 1;
            rd_run = 0;
            hi_run = hi_run + 1;
        end
        prev_we = mem_we_n;
        prev_rd = rd;
    end

    function automatic logic [7:0] bval(input logic [7:0] seed, input int i);
        return seed + 8'(i * 37);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Issue one command, feed bytes with a given pre-delay, wait for the result
    task automatic run_burst(input logic [12:0] addr, input logic [5:0] lenm1,
                             input logic mode, input int delay, input logic [7:0] seed);
        loads = 0; reads = 0; gap_max = 0; pulse_bad = 0; setup_bad = 0;
        read_bad = 0; page_bad = 0; exp_page = addr[12:6];
        got_done = 0; got_err = 0; burst_over = 0; post_ok = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_addr = addr; cmd_len = lenm1; cmd_mode = mode;
        @(negedge clk);
        cmd_valid = 0;
        // R1: busy from acceptance onward
        chk(cmd_ready == 1'b0, "R1 ready low after accept", int'(cmd_ready), 0);
        fork
            begin
                for (int i = 0; i <= int'(lenm1) && !burst_over; i++) begin
                    if (i > 0) repeat (delay) @(negedge clk);
                    dat_valid = 1; dat_byte = bval(seed, i);
                    while (!dat_ready && !burst_over) @(negedge clk);
                    if (!burst_over) @(negedge clk);
                    dat_valid = 0;
                end
            end
            begin
                int w;
                w = 0;
                while (!done && !err && w < 5000) begin
                    @(negedge clk);
                    w++;
                end
                got_done = done; got_err = err; cut_at_end = cut;
                busy_at_done = busy_cnt; end_cyc = cyc;
                burst_over = 1;
                @(negedge clk);
                post_ok = !done && !err && cmd_ready;
            end
        join
        dat_valid = 0;
    endtask

    task automatic check_bytes(input logic [12:0] addr, input int n, input logic [7:0] seed, input string req);
        for (int i = 0; i < n; i++) begin
            int c;
            c = (int'(addr[5:0]) + i) % 64;
            chk(mem_pg[c] == bval(seed, i), req, int'(mem_pg[c]), int'(bval(seed, i)));
        end
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(cmd_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_doe && !done && !err,
            "R1 reset state", {cmd_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_doe}, 5'b11110);
    endtask

    task automatic t_data_poll();
        run_burst(13'h1A3C, 6'd3, 1'b0, 0, 8'h81);
        chk(got_done && !got_err, "R7 done in data mode", int'(got_done), 1);
        chk(busy_at_done == 0, "R7 no done while busy", busy_at_done, 0);
        chk(reads >= 2, "R7 polled more than once", reads, 2);
        chk(loads == 4, "R3 load count", loads, 4);
        chk(page_bad == 0, "R3 page fixed", page_bad, 0);
        check_bytes(13'h1A3C, 4, 8'h81, "R3 byte placement");
        chk(pulse_bad == 0 && setup_bad == 0, "R2 strobe timing", pulse_bad + setup_bad, 0);
        chk(read_bad == 0, "R6 read timing and address", read_bad, 0);
        chk(gap_max < T_GAP_MAX, "R4 load spacing", gap_max, T_GAP_MAX - 1);
        chk(!cut_at_end, "R5 cut low on full burst", int'(cut_at_end), 0);
        chk(post_ok, "R10 done single pulse then idle", int'(post_ok), 1);
    endtask

    task automatic t_toggle_one();
        run_burst(13'h0455, 6'd0, 1'b1, 0, 8'h3C);
        chk(got_done && !got_err, "R8 done in toggle mode", int'(got_done), 1);
        chk(busy_at_done == 0, "R8 no done while bit toggles", busy_at_done, 0);
        chk(loads == 1, "R3 single byte", loads, 1);
        check_bytes(13'h0455, 1, 8'h3C, "R3 single byte placement");
        chk(read_bad == 0, "R6 toggle reads", read_bad, 0);
        chk(post_ok, "R10 toggle done pulse", int'(post_ok), 1);
    endtask

    task automatic t_wrap_slow();
        run_burst({7'h15, 6'd62}, 6'd3, 1'b1, 15, 8'hC7);
        chk(got_done, "R8 done after wrap burst", int'(got_done), 1);
        chk(loads == 4, "R4 late bytes still accepted", loads, 4);
        chk(gap_max < T_GAP_MAX, "R4 spacing with slow feed", gap_max, T_GAP_MAX - 1);
        chk(page_bad == 0, "R3 page fixed across wrap", page_bad, 0);
        check_bytes({7'h15, 6'd62}, 4, 8'hC7, "R3 column wrap");
        chk(!cut_at_end, "R5 cut low with slow feed", int'(cut_at_end), 0);
    endtask

    task automatic t_stall_cut();
        run_burst(13'h0A10, 6'd5, 1'b0, 30, 8'h5A);
        chk(cut_at_end, "R5 cut set on stall", int'(cut_at_end), 1);
        chk(loads == 1, "R5 remaining bytes dropped", loads, 1);
        chk(got_done && busy_at_done == 0, "R5 polls last loaded byte", int'(got_done), 1);
        chk(read_bad == 0, "R6 reads target last loaded address", read_bad, 0);
        check_bytes(13'h0A10, 1, 8'h5A, "R5 first byte kept");
    endtask

    task automatic t_full_page();
        run_burst({7'h7F, 6'd0}, 6'd63, 1'b0, 0, 8'h11);
        chk(loads == 64, "R3 full page count", loads, 64);
        check_bytes({7'h7F, 6'd0}, 64, 8'h11, "R3 full page data");
        chk(pulse_bad == 0 && setup_bad == 0, "R2 full page strobes", pulse_bad + setup_bad, 0);
        chk(got_done, "R7 full page done", int'(got_done), 1);
    endtask

    task automatic t_timeout();
        int dt;
        prog_len = 1000000;
        run_burst(13'h1234, 6'd0, 1'b0, 0, 8'h77);
        dt = end_cyc - first_rd_cyc;
        chk(got_err && !got_done, "R9 err without done", int'(got_err), 1);
        chk(dt >= T_TIMEOUT - T_REC && dt <= T_TIMEOUT + T_RD + 2, "R9 timeout window",
            dt, T_TIMEOUT);
        chk(post_ok, "R10 err single pulse then idle", int'(post_ok), 1);
        busy_cnt = 0;
        prog_len = PROG_DEF;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem_pg[i] = 8'h00;
        t_reset();
        t_data_poll();
        t_toggle_one();
        t_wrap_slow();
        t_stall_cut();
        t_full_page();
        t_timeout();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule